// File: doc/BRIEF.md
# Grouped-Priority Preemption Arbiter

This block decides which of a set of interrupt requests should be serviced next, and whether that request may interrupt the handler that is already running. Each request line has an 8-bit urgency field. A lower numeric value means more urgent. A run-time grouping field splits every urgency value at a chosen bit. The upper bits form the group part, and only the group part decides preemption. The lower bits form the subpriority, and it only orders requests that are waiting at the same time.

Software programs the urgency fields and the grouping field through a word-wide write port that has per-byte enables. A processor-side agent watches the selection and the preempt flag. It pulses `take` to accept the selected request. It pulses `done` when the innermost handler returns. The block keeps a pending flag for each request and a stack of nested active handlers. It reports which handler is innermost and the group value that is currently running.

Top module: `prio_preempt_arb`

## Requirements
- R1: After reset, all urgency fields and the grouping field are 0, nothing is pending or active, and `sel_valid`, `preempt_req`, `busy`, `run_grp` and `cfg_rdata` are 0.
- R2: Word address 0 holds the grouping field in bits [2:0], written when byte enable 0 is set; its other bits read as 0. Word address k (k ≥ 1) holds the urgency fields of requests 4(k-1)+j in byte lane j, bits [8j+7:8j]. A write changes only the lanes whose byte enable is set, and `cfg_rdata` returns the word at `cfg_addr` combinationally.
- R3: `sel_id` names the pending request with the numerically smallest 8-bit urgency field. On a full tie, the lowest request number wins. `sel_valid` is 1 exactly when some request is pending.
- R4: While no handler is active, `preempt_req` equals `sel_valid`.
- R5: Let g be the grouping value. The group part is bits [7:g+1] and the subpriority is bits [g:0]. While a handler is active, `preempt_req` is 1 only when the selected request's group part is strictly smaller than the running handler's group part. A same-group request with a smaller subpriority does not preempt.
- R6: With a grouping value of 7, no request can preempt an active handler.
- R7: A `take` pulse while `preempt_req` is 1 (and `done` is 0) clears that request's pending flag. It pushes the request as the innermost handler, so `busy` is 1, `cur_id` is the taken request and `run_grp` is its urgency field with the subpriority bits cleared. A `take` while `preempt_req` is 0 has no effect.
- R8: A `done` pulse removes the innermost handler, so the previous handler's group becomes the running one again. With no handler active, `done` has no effect. A same-group request that waited during a handler becomes eligible once that handler is gone. `done` takes precedence over a `take` in the same cycle.
- R9: A change to the grouping field is seen by the outputs from the next cycle. The change does not alter the pending or active state.
- R10: A pulse on bit i of `irq_set` makes request i pending from the next cycle. It stays pending until it is taken. A set in the same cycle as its own take leaves it pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Word address for write and read |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the word at cfg_addr |
| irq_set | input | N_REQ | Per-request set pulses |
| take | input | 1 | Accept the selected request |
| done | input | 1 | Innermost handler has returned |
| sel_valid | output | 1 | Some request is pending |
| sel_id | output | ID_W | Selected pending request |
| preempt_req | output | 1 | Selected request may start now |
| busy | output | 1 | At least one handler is active |
| cur_id | output | ID_W | Innermost active handler |
| run_grp | output | 8 | Running group value, subpriority bits cleared (0 when idle) |

## Verification
The hardest situation to reach from the ports is a more-urgent request in the same group arriving while a handler is active. It must wait through that handler and then be granted after the `done` pulse. The stimulus gets there by building a two-deep nest first. It then raises same-group requests at each level and pops the nest one level at a time. Changing the grouping field under an active handler moves the split point across the two urgency values involved. This turns a blocked request into a preempting one and then blocks everything with a grouping value of 7.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  localparam int PRIO_W = 8;
  localparam int GSEL_W = 3;

  // mask of the subpriority bits [g:0]
  function automatic logic [PRIO_W-1:0] sub_mask(input logic [GSEL_W-1:0] g);
    logic [PRIO_W:0] m;
    m = (9'd2 << g) - 9'd1;
    return m[PRIO_W-1:0];
  endfunction

  // urgency value with the subpriority bits cleared
  function automatic logic [PRIO_W-1:0] group_part(input logic [PRIO_W-1:0] p,
                                                   input logic [GSEL_W-1:0] g);
    return p & ~sub_mask(g);
  endfunction
endpackage

// File: rtl/ppa_regs.sv
module ppa_regs
  import ppa_pkg::*;
#(
  parameter int N_REQ  = 8,
  parameter int ADDR_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [3:0]                    be,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output logic [N_REQ-1:0][PRIO_W-1:0]  prio,
  output logic [GSEL_W-1:0]             gsel
);
  always_ff @(posedge clk) begin
    if (!rst_n) gsel <= '0;
    else if (we && addr == '0 && be[0]) gsel <= wdata[GSEL_W-1:0];
  end

  for (genvar i = 0; i < N_REQ; i++) begin : g_lane
    localparam int WORD = i / 4 + 1;
    localparam int LANE = i % 4;
    logic hit;
    assign hit = we && (addr == ADDR_W'(WORD)) && be[LANE];
    always_ff @(posedge clk) begin
      if (!rst_n)   prio[i] <= '0;
      else if (hit) prio[i] <= wdata[LANE*8 +: 8];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata[GSEL_W-1:0] = gsel;
    for (int i = 0; i < N_REQ; i++)
      if (addr == ADDR_W'(i / 4 + 1)) rdata[(i % 4)*8 +: 8] = prio[i];
  end

  // R9
  gsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == '0 && be[0]) |=> $stable(gsel));
endmodule

// File: rtl/ppa_pend.sv
module ppa_pend #(
  parameter int N_REQ = 8,
  parameter int ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] set,
  input  logic             clr,
  input  logic [ID_W-1:0]  clr_id,
  output logic [N_REQ-1:0] pend
);
  logic [N_REQ-1:0] clr_vec;
  assign clr_vec = clr ? (N_REQ'(1) << clr_id) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | set;
  end

  // R10
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> (|pend));
endmodule

// File: rtl/ppa_select.sv
module ppa_select
  import ppa_pkg::*;
#(
  parameter int N_REQ = 8,
  parameter int ID_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_REQ-1:0]              pend,
  input  logic [N_REQ-1:0][PRIO_W-1:0]  prio,
  output logic                          valid,
  output logic [ID_W-1:0]               id,
  output logic [PRIO_W-1:0]             best
);
  // strict compare in ascending order keeps the lowest number on a tie
  always_comb begin
    valid = 1'b0;
    id    = '0;
    best  = '1;
    for (int i = 0; i < N_REQ; i++) begin
      if (pend[i] && (!valid || prio[i] < best)) begin
        valid = 1'b1;
        id    = ID_W'(i);
        best  = prio[i];
      end
    end
  end

  // R3
  sel_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> pend[id]);
endmodule

// File: rtl/ppa_stack.sv
module ppa_stack #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  input  logic            pop,
  output logic            busy,
  output logic            full,
  output logic [ID_W-1:0] top_id
);
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [ID_W-1:0] stk [DEPTH];
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] sp_m1;

  assign busy   = (sp != '0);
  assign full   = (sp == SP_W'(DEPTH));
  assign sp_m1  = sp - SP_W'(1);
  assign top_id = busy ? stk[sp_m1[ID_W-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
    end else if (pop && busy) begin
      sp <= sp_m1;
    end else if (push && !full) begin
      stk[sp[ID_W-1:0]] <= push_id;
      sp <= sp + SP_W'(1);
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !busy && !push) |=> !busy);
endmodule

// File: rtl/prio_preempt_arb.sv
module prio_preempt_arb
  import ppa_pkg::*;
#(
  parameter int N_REQ    = 8,
  localparam int ID_W    = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int N_WORDS = (N_REQ + 3) / 4,
  localparam int ADDR_W  = $clog2(N_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [N_REQ-1:0]  irq_set,
  input  logic              take,
  input  logic              done,
  output logic              sel_valid,
  output logic [ID_W-1:0]   sel_id,
  output logic              preempt_req,
  output logic              busy,
  output logic [ID_W-1:0]   cur_id,
  output logic [7:0]        run_grp
);
  logic [N_REQ-1:0][PRIO_W-1:0] prio;
  logic [GSEL_W-1:0]            gsel;
  logic [N_REQ-1:0]             pend;
  logic [PRIO_W-1:0]            sel_prio;
  logic                         stk_full;
  logic [PRIO_W-1:0]            sel_grp, act_grp;
  logic                         grp_wins;
  logic                         take_ok;

  ppa_regs #(.N_REQ(N_REQ), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .be(cfg_be),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .prio(prio), .gsel(gsel));

  ppa_pend #(.N_REQ(N_REQ), .ID_W(ID_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(take_ok), .clr_id(sel_id),
    .pend(pend));

  ppa_select #(.N_REQ(N_REQ), .ID_W(ID_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .pend(pend), .prio(prio), .valid(sel_valid),
    .id(sel_id), .best(sel_prio));

  ppa_stack #(.DEPTH(N_REQ), .ID_W(ID_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(take_ok), .push_id(sel_id), .pop(done),
    .busy(busy), .full(stk_full), .top_id(cur_id));

  // named internal events for the checks below
  assign sel_grp     = group_part(sel_prio, gsel);
  assign act_grp     = group_part(prio[cur_id], gsel);
  assign grp_wins    = sel_grp < act_grp;
  assign preempt_req = sel_valid && (!busy || grp_wins);
  assign take_ok     = take && preempt_req && !done && !stk_full;
  assign run_grp     = busy ? act_grp : '0;

  // R7
  take_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> busy && cur_id == $past(sel_id));
  // R6
  no_preempt_g7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && gsel == 3'd7) |-> !preempt_req);
  // R9
  cfg_keeps_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !take && !done) |=> busy == $past(busy) && cur_id == $past(cur_id));
  // R4
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sel_valid) |-> preempt_req);
endmodule

// File: tb/prio_preempt_arb_tb.sv
`timescale 1ns/100ps
module prio_preempt_arb_tb;
  localparam int N = 8;

  typedef struct {
    bit         v;
    int         sid;
    bit         pre;
    bit         bsy;
    int         cid;
    int         rg;
    logic [31:0] rd;
    string      tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [N-1:0] irq_set = 0;
  logic take = 0, done = 0;
  logic sel_valid, preempt_req, busy;
  logic [2:0] sel_id, cur_id;
  logic [7:0] run_grp;

  always #2 clk = ~clk;

  prio_preempt_arb u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_set(irq_set), .take(take), .done(done), .sel_valid(sel_valid),
    .sel_id(sel_id), .preempt_req(preempt_req), .busy(busy),
    .cur_id(cur_id), .run_grp(run_grp));

  int checks = 0, errors = 0;
  bit finished = 0;
  exp_t exp_q[$];

  // reference model
  int m_prio[N];
  int m_g;
  bit m_pend[N];
  int m_stk[$];

  function automatic int grp(input int p);
    return p / (1 << (m_g + 1));
  endfunction

  function automatic void msel(output bit v, output int id);
    v = 0; id = 0;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && (!v || m_prio[i] < m_prio[id])) begin v = 1; id = i; end
  endfunction

  function automatic bit mpre();
    bit v; int id;
    msel(v, id);
    if (!v) return 0;
    if (m_stk.size() == 0) return 1;
    return grp(m_prio[id]) < grp(m_prio[m_stk[$]]);
  endfunction

  function automatic logic [31:0] mread(input int a);
    logic [31:0] r = 0;
    if (a == 0) r[2:0] = m_g[2:0];
    else for (int j = 0; j < 4; j++)
      if (4*(a-1)+j < N) r[8*j +: 8] = m_prio[4*(a-1)+j][7:0];
    return r;
  endfunction

  task automatic step(input bit we, input int addr, input logic [3:0] be,
                      input logic [31:0] wd, input logic [N-1:0] set,
                      input bit tk, input bit dn, input string tag);
    bit v, pre, tok; int id; exp_t e;
    @(negedge clk);
    cfg_we = we; cfg_addr = addr[1:0]; cfg_be = be; cfg_wdata = wd;
    irq_set = set; take = tk; done = dn;
    msel(v, id);
    pre = mpre();
    tok = tk && pre && !dn && m_stk.size() < N;
    if (we) begin
      if (addr == 0 && be[0]) m_g = wd[2:0];
      else if (addr > 0)
        for (int j = 0; j < 4; j++)
          if (be[j] && 4*(addr-1)+j < N) m_prio[4*(addr-1)+j] = wd[8*j +: 8];
    end
    if (tok) m_pend[id] = 0;
    for (int i = 0; i < N; i++) if (set[i]) m_pend[i] = 1;
    if (dn && m_stk.size() > 0) void'(m_stk.pop_back());
    else if (tok) m_stk.push_back(id);
    @(posedge clk);
    #1;
    cfg_we = 0; irq_set = 0; take = 0; done = 0;
    msel(e.v, e.sid);
    e.pre = mpre();
    e.bsy = m_stk.size() > 0;
    e.cid = e.bsy ? m_stk[$] : 0;
    e.rg  = e.bsy ? grp(m_prio[m_stk[$]]) * (1 << (m_g + 1)) : 0;
    e.rd  = mread(addr);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare each expected item against the ports
  initial begin
    exp_t e;
    forever begin
      wait (exp_q.size() > 0);
      #0.5;
      e = exp_q.pop_front();
      checks++;
      if (sel_valid !== e.v || (e.v && sel_id !== e.sid[2:0]) ||
          preempt_req !== e.pre || busy !== e.bsy ||
          (e.bsy && cur_id !== e.cid[2:0]) || run_grp !== e.rg[7:0] ||
          cfg_rdata !== e.rd) begin
        errors++;
        $display("FAIL %s: actual v=%0b id=%0d pre=%0b busy=%0b cur=%0d grp=%h rd=%h expected v=%0b id=%0d pre=%0b busy=%0b cur=%0d grp=%h rd=%h",
          e.tag, sel_valid, sel_id, preempt_req, busy, cur_id, run_grp, cfg_rdata,
          e.v, e.sid, e.pre, e.bsy, e.cid, e.rg[7:0], e.rd);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_g = 0;
    for (int i = 0; i < N; i++) begin m_prio[i] = 0; m_pend[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, "R1 reset state");
    step(0, 1, 0, 0, 0, 0, 0, "R1 reset urgency read");
    // configuration
    step(1, 0, 4'b0001, 32'hFFFF_FF03, 0, 0, 0, "R2 grouping write");
    step(1, 1, 4'b1111, 32'h2031_3040, 0, 0, 0, "R2 word write 1");
    step(1, 2, 4'b1111, 32'h1050_5021, 0, 0, 0, "R2 word write 2");
    step(1, 2, 4'b0010, 32'h00AB_CD00, 0, 0, 0, "R2 single lane write");
    step(1, 2, 4'b0010, 32'h0000_5000, 0, 0, 0, "R2 lane restore");
    // same-group pair, subpriority ordering
    step(0, 1, 0, 0, 8'b0000_0110, 0, 0, "R10 set 1 and 2");
    step(0, 1, 0, 0, 0, 0, 0, "R3 R4 sub order idle grant");
    step(0, 1, 0, 0, 0, 1, 0, "R7 take 1");
    step(0, 1, 0, 0, 0, 1, 0, "R5 R7 same group take ignored");
    step(0, 1, 0, 0, 8'b0000_1001, 0, 0, "R5 more urgent group arrives");
    step(0, 1, 0, 0, 0, 1, 0, "R7 take 3 nests");
    step(0, 1, 0, 0, 8'b0001_0000, 0, 0, "R5 same group as 3 waits");
    step(0, 1, 0, 0, 0, 0, 1, "R8 exit 3 frees 4");
    step(0, 1, 0, 0, 0, 1, 0, "R7 take 4");
    step(0, 1, 0, 0, 0, 0, 1, "R8 exit 4 back to 1");
    step(0, 1, 0, 0, 0, 0, 1, "R8 exit 1 same group 2 now eligible");
    step(0, 1, 0, 0, 0, 1, 1, "R8 done wins over take when idle");
    step(0, 1, 0, 0, 0, 1, 0, "R7 take 2");
    step(0, 1, 0, 0, 0, 0, 1, "R8 exit 2");
    step(0, 1, 0, 0, 0, 1, 0, "R7 take 0");
    step(0, 1, 0, 0, 0, 0, 1, "R8 exit 0");
    step(0, 1, 0, 0, 0, 0, 1, "R8 done on empty ignored");
    // full tie
    step(0, 2, 0, 0, 8'b0110_0000, 0, 0, "R10 set 5 and 6");
    step(0, 2, 0, 0, 0, 0, 0, "R3 tie lowest number");
    step(0, 2, 0, 0, 8'b0010_0000, 1, 0, "R10 set with own take stays pending");
    step(0, 2, 0, 0, 0, 0, 1, "R8 exit 5");
    step(0, 2, 0, 0, 0, 1, 0, "R3 take 5 again");
    step(0, 2, 0, 0, 0, 0, 1, "R8 exit");
    step(0, 2, 0, 0, 0, 1, 0, "R3 take 6");
    step(0, 2, 0, 0, 0, 0, 1, "R8 exit 6");
    // grouping change under an active handler
    step(1, 1, 4'b0011, 32'h0000_2024, 0, 0, 0, "R2 reprogram 0 and 1");
    step(0, 1, 0, 0, 8'b0000_0001, 0, 0, "R10 set 0");
    step(0, 1, 0, 0, 0, 1, 0, "R7 take 0");
    step(0, 1, 0, 0, 8'b0000_0010, 0, 0, "R5 same group at split 3");
    step(1, 0, 4'b0001, 32'h0000_0001, 0, 0, 0, "R9 split 1 enables preempt");
    step(0, 0, 0, 0, 0, 0, 0, "R9 state kept");
    step(1, 0, 4'b0001, 32'h0000_0007, 0, 0, 0, "R6 split 7 blocks");
    step(1, 1, 4'b0010, 32'h0000_0000, 0, 0, 0, "R6 most urgent still blocked");
    step(0, 1, 0, 0, 0, 1, 0, "R6 take ignored");
    step(0, 1, 0, 0, 0, 0, 1, "R8 exit then grant");
    step(0, 1, 0, 0, 0, 0, 0, "R4 idle grant");
    wait (exp_q.size() == 0);
    #2;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule